// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a bank of rising-edge registers that sits between a memory controller and the devices on a memory module. It captures the command and address lanes and drives them back out one clock later. Two static strap inputs select the topology. In the wide topology, 25 input lanes each drive one output. In the paired topology, the lower 14 lanes are registered once, and each register drives a primary copy and a secondary copy. The paired topology has two lane mappings, and the strap that selects between them moves the clock-enable and termination lanes to different lane positions.

Two active-low chip-select inputs save power. When both are sampled high, the ordinary data lanes keep their previous value. The clock-enable lane, the termination lane and the registered chip-select output keep loading on every edge. An asynchronous active-low reset clears every register at once and has priority over the chip-select freeze.

Top module: `cmdbuf_top`

## Requirements
- R1: With `dcs_n` or `csr_n` low at a rising edge, every data lane `q_a[i]` takes the value `ball_in[i]` sampled at that edge.
- R2: With `cfg_pair`=1, `q_b[j]` equals `q_a[j]` for every j in 0..13, and `q_cs_b` equals `q_cs_a`.
- R3: With `cfg_pair`=1 and `cfg_sel_b`=1, the control lanes are lane 13 (clock enable) and lane 10 (termination). Each control lane loads `ball_in` on every edge, even while the data lanes are frozen.
- R4: When `dcs_n` and `csr_n` are both high at a rising edge, every data lane keeps its previous value.
- R5: With `cfg_pair`=0, or with `cfg_sel_b`=0, the control lanes are lane 0 (clock enable) and lane 3 (termination). Each control lane loads on every edge, whatever the chip-select inputs are.
- R6: While `rst_n` is low, every output is 0. The outputs clear without waiting for a clock edge, even if the freeze condition holds.
- R7: With `cfg_pair`=0, `q_b` and `q_cs_b` are held at 0.
- R8: Lane 6 has no function and its output `q_a[6]` is always 0. With `cfg_pair`=1, `q_a[24:14]` are also always 0.
- R9: If `rst_n` is released while every input is low, all outputs stay 0 on the following edges.
- R10: `q_cs_a` equals `dcs_n` as sampled at the previous rising edge, and the freeze never affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pair | input | 1 | Strap: 0 selects wide 1:1, 1 selects paired 1:2 |
| cfg_sel_b | input | 1 | Strap: selects the second lane mapping in paired mode |
| dcs_n | input | 1 | Chip select, active low; also registered to `q_cs_a` |
| csr_n | input | 1 | Second chip select, active low; used only for freezing |
| ball_in | input | 25 | Command and address input lanes |
| q_a | output | 25 | Registered primary copy of the lanes |
| q_b | output | 14 | Secondary copy of lanes 0..13 (paired mode only) |
| q_cs_a | output | 1 | Registered chip select, primary copy |
| q_cs_b | output | 1 | Registered chip select, secondary copy (paired mode only) |

## Verification
The data, control and chip-select results appear one rising edge after the inputs that produce them. The secondary copies appear in the same cycle as the primary copies, and the reset clear needs no edge at all. The bench drives inputs on the falling edge and advances its behavioural model at the rising edge. It compares every output bit at the next falling edge, so each comparison sits exactly one register stage after its stimulus. The reset clear is checked a fraction of a nanosecond after `rst_n` falls, between two edges, so it cannot rely on a clock edge.

// File: rtl/cmdbuf_pkg.sv
`timescale 1ns/1ps
package cmdbuf_pkg;

  typedef enum logic [1:0] {
    TOPO_WIDE   = 2'd0,
    TOPO_PAIR_A = 2'd1,
    TOPO_PAIR_B = 2'd2
  } topo_e;

  // Straps to topology; the selector strap only matters in paired mode.
  function automatic topo_e decode_topo(input logic pair, input logic sel_b);
    if (!pair)     return TOPO_WIDE;
    else if (sel_b) return TOPO_PAIR_B;
    else           return TOPO_PAIR_A;
  endfunction

endpackage

// File: rtl/cmdbuf_role_map.sv
`timescale 1ns/1ps
module cmdbuf_role_map
  import cmdbuf_pkg::*;
#(
  parameter int LANES    = 25,
  parameter int HALF     = 14,
  parameter int GAP_LANE = 6,
  parameter int CKE_A    = 0,
  parameter int ODT_A    = 3,
  parameter int CKE_B    = 13,
  parameter int ODT_B    = 10
) (
  input  topo_e              topo,
  output logic [LANES-1:0]   live_mask,
  output logic [LANES-1:0]   ctrl_mask
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit IS_GAP   = (i == GAP_LANE);
    localparam bit IN_HALF  = (i < HALF);
    localparam bit CTRL_A   = (i == CKE_A) || (i == ODT_A);
    localparam bit CTRL_B   = (i == CKE_B) || (i == ODT_B);

    always_comb begin
      live_mask[i] = !IS_GAP && ((topo == TOPO_WIDE) || IN_HALF);
      ctrl_mask[i] = (topo == TOPO_PAIR_B) ? CTRL_B : CTRL_A;
    end
  end

endmodule

// File: rtl/cmdbuf_stage.sv
`timescale 1ns/1ps
module cmdbuf_stage #(
  parameter int LANES = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] d,
  input  logic [LANES-1:0] live_mask,
  input  logic [LANES-1:0] ctrl_mask,
  input  logic             dcs_n,
  input  logic             csr_n,
  output logic [LANES-1:0] q,
  output logic             cs_q
);

  // Both selects deasserted: ordinary lanes stay put.
  logic freeze;
  assign freeze = dcs_n & csr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      cs_q <= 1'b0;
    end else begin
      cs_q <= dcs_n;
      for (int i = 0; i < LANES; i++) begin
        if (!live_mask[i])
          q[i] <= 1'b0;
        else if (ctrl_mask[i] || !freeze)
          q[i] <= d[i];
      end
    end
  end

endmodule

// File: rtl/cmdbuf_fanout.sv
`timescale 1ns/1ps
module cmdbuf_fanout #(
  parameter int LANES = 25,
  parameter int HALF  = 14
) (
  input  logic             pair,
  input  logic [LANES-1:0] stage_q,
  input  logic             cs_q,
  output logic [LANES-1:0] q_a,
  output logic [HALF-1:0]  q_b,
  output logic             q_cs_a,
  output logic             q_cs_b
);

  assign q_a    = stage_q;
  assign q_cs_a = cs_q;
  assign q_cs_b = pair & cs_q;

  for (genvar j = 0; j < HALF; j++) begin : g_copy
    assign q_b[j] = pair & stage_q[j];
  end

endmodule

// File: rtl/cmdbuf_top.sv
`timescale 1ns/1ps
module cmdbuf_top
  import cmdbuf_pkg::*;
#(
  parameter int LANES    = 25,
  parameter int HALF     = 14,
  parameter int GAP_LANE = 6,
  parameter int CKE_A    = 0,
  parameter int ODT_A    = 3,
  parameter int CKE_B    = HALF - 1,
  parameter int ODT_B    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pair,
  input  logic             cfg_sel_b,
  input  logic             dcs_n,
  input  logic             csr_n,
  input  logic [LANES-1:0] ball_in,
  output logic [LANES-1:0] q_a,
  output logic [HALF-1:0]  q_b,
  output logic             q_cs_a,
  output logic             q_cs_b
);

  topo_e            topo;
  logic [LANES-1:0] live_mask;
  logic [LANES-1:0] ctrl_mask;
  logic [LANES-1:0] stage_q;
  logic             cs_q;

  assign topo = decode_topo(cfg_pair, cfg_sel_b);

  cmdbuf_role_map #(
    .LANES(LANES), .HALF(HALF), .GAP_LANE(GAP_LANE),
    .CKE_A(CKE_A), .ODT_A(ODT_A), .CKE_B(CKE_B), .ODT_B(ODT_B)
  ) u_map (
    .topo      (topo),
    .live_mask (live_mask),
    .ctrl_mask (ctrl_mask)
  );

  cmdbuf_stage #(.LANES(LANES)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .d         (ball_in),
    .live_mask (live_mask),
    .ctrl_mask (ctrl_mask),
    .dcs_n     (dcs_n),
    .csr_n     (csr_n),
    .q         (stage_q),
    .cs_q      (cs_q)
  );

  cmdbuf_fanout #(.LANES(LANES), .HALF(HALF)) u_fan (
    .pair    (cfg_pair),
    .stage_q (stage_q),
    .cs_q    (cs_q),
    .q_a     (q_a),
    .q_b     (q_b),
    .q_cs_a  (q_cs_a),
    .q_cs_b  (q_cs_b)
  );

endmodule

// File: rtl/cmdbuf_checker.sv
`timescale 1ns/1ps
module cmdbuf_checker #(
  parameter int LANES = 25,
  parameter int HALF  = 14,
  parameter int CKE_A = 0,
  parameter int ODT_A = 3,
  parameter int CKE_B = HALF - 1,
  parameter int ODT_B = 10,
  parameter int GAP_LANE = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_pair,
  input logic             cfg_sel_b,
  input logic             dcs_n,
  input logic             csr_n,
  input logic [LANES-1:0] ball_in,
  input logic [LANES-1:0] q_a,
  input logic [HALF-1:0]  q_b,
  input logic             q_cs_a,
  input logic             q_cs_b
);

  // Lane 1 is an ordinary data lane in every topology.
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dcs_n || !csr_n) |=> q_a[1] == $past(ball_in[1]));

  p_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pair |-> (q_b == q_a[HALF-1:0]) && (q_cs_b == q_cs_a));

  p_ctrl_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pair && cfg_sel_b) |=> (q_a[CKE_B] == $past(ball_in[CKE_B]))
                              && (q_a[ODT_B] == $past(ball_in[ODT_B])));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dcs_n && csr_n) |=> q_a[1] == $past(q_a[1]));

  p_ctrl_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pair || !cfg_sel_b) |=> (q_a[CKE_A] == $past(ball_in[CKE_A]))
                                && (q_a[ODT_A] == $past(ball_in[ODT_A])));

  p_wide_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pair |-> (q_b == '0) && !q_cs_b);

  p_gap_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !q_a[GAP_LANE]);

  p_upper_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pair |-> q_a[LANES-1:HALF] == '0);

  p_cs_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q_cs_a == $past(dcs_n));

  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r6: assert (q_a == '0 && q_b == '0 && !q_cs_a && !q_cs_b);
    end
  end

endmodule

bind cmdbuf_top cmdbuf_checker #(
  .LANES(LANES), .HALF(HALF), .CKE_A(CKE_A), .ODT_A(ODT_A),
  .CKE_B(CKE_B), .ODT_B(ODT_B), .GAP_LANE(GAP_LANE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pair(cfg_pair), .cfg_sel_b(cfg_sel_b),
  .dcs_n(dcs_n), .csr_n(csr_n), .ball_in(ball_in), .q_a(q_a), .q_b(q_b),
  .q_cs_a(q_cs_a), .q_cs_b(q_cs_b)
);

// File: tb/tb_cmdbuf_top.sv
`timescale 1ns/1ps
module tb_cmdbuf_top;
  localparam int LANES = 25;
  localparam int HALF  = 14;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             cfg_pair = 1'b0;
  logic             cfg_sel_b = 1'b0;
  logic             dcs_n = 1'b0;
  logic             csr_n = 1'b0;
  logic [LANES-1:0] ball_in = '0;
  logic [LANES-1:0] q_a;
  logic [HALF-1:0]  q_b;
  logic             q_cs_a;
  logic             q_cs_b;

  cmdbuf_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_pair(cfg_pair), .cfg_sel_b(cfg_sel_b),
    .dcs_n(dcs_n), .csr_n(csr_n), .ball_in(ball_in),
    .q_a(q_a), .q_b(q_b), .q_cs_a(q_cs_a), .q_cs_b(q_cs_b)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string force_tag = "";
  bit    was_frozen = 1'b0;

  // Behavioural reference state
  bit    ref_a [LANES];
  bit    ref_cs;

  function automatic bit lane_is_ctrl(int ln);
    if (cfg_pair && cfg_sel_b) return (ln == 13) || (ln == 10);
    return (ln == 0) || (ln == 3);
  endfunction

  function automatic bit lane_is_dead(int ln);
    return (ln == 6) || (cfg_pair && ln >= HALF);
  endfunction

  task automatic check_bit(string tag, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic ref_clear();
    for (int i = 0; i < LANES; i++) ref_a[i] = 1'b0;
    ref_cs = 1'b0;
  endtask

  task automatic compare_all();
    string tag;
    for (int i = 0; i < LANES; i++) begin
      if (force_tag != "")     tag = force_tag;
      else if (lane_is_dead(i)) tag = "R8";
      else if (lane_is_ctrl(i)) tag = (cfg_pair && cfg_sel_b) ? "R3" : "R5";
      else if (was_frozen)      tag = "R4";
      else                      tag = "R1";
      check_bit(tag, $sformatf("q_a[%0d]", i), q_a[i], ref_a[i]);
    end
    for (int j = 0; j < HALF; j++) begin
      tag = (force_tag != "") ? force_tag : (cfg_pair ? "R2" : "R7");
      check_bit(tag, $sformatf("q_b[%0d]", j), q_b[j], cfg_pair ? ref_a[j] : 1'b0);
    end
    check_bit((force_tag != "") ? force_tag : "R10", "q_cs_a", q_cs_a, ref_cs);
    check_bit((force_tag != "") ? force_tag : (cfg_pair ? "R2" : "R7"),
              "q_cs_b", q_cs_b, cfg_pair ? ref_cs : 1'b0);
  endtask

  // One clock: model advances at the rising edge, compare at the falling edge.
  task automatic tick();
    bit frz;
    @(posedge clk);
    frz = dcs_n && csr_n;
    if (!rst_n) ref_clear();
    else begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_is_dead(i))                  ref_a[i] = 1'b0;
        else if (lane_is_ctrl(i) || !frz)     ref_a[i] = ball_in[i];
      end
      ref_cs = dcs_n;
    end
    was_frozen = frz;
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive_random(int freeze_bias);
    ball_in = LANES'($urandom);
    if (($urandom % 100) < freeze_bias) begin
      dcs_n = 1'b1; csr_n = 1'b1;
    end else begin
      dcs_n = 1'($urandom); csr_n = 1'($urandom);
      if (dcs_n && csr_n) csr_n = 1'b0;
    end
  endtask

  task automatic run_topology(bit pair, bit sel_b, int cycles);
    rst_n = 1'b0;
    cfg_pair = pair; cfg_sel_b = sel_b;
    ball_in = '0; dcs_n = 1'b0; csr_n = 1'b0;
    force_tag = "R6";
    repeat (2) tick();
    rst_n = 1'b1;                      // released with all inputs low
    force_tag = "R9";
    repeat (3) tick();
    force_tag = "";
    for (int c = 0; c < cycles; c++) begin
      drive_random(40);
      tick();
    end
  endtask

  task automatic async_reset_probe();
    // Freeze active, then reset lands between edges
    dcs_n = 1'b1; csr_n = 1'b1; ball_in = '1;
    #0.5 rst_n = 1'b0;
    #0.5;
    check_bit("R6", "q_a async", |q_a, 1'b0);
    check_bit("R6", "q_b async", |q_b, 1'b0);
    check_bit("R6", "q_cs_a async", q_cs_a, 1'b0);
    check_bit("R6", "q_cs_b async", q_cs_b, 1'b0);
    ref_clear();
  endtask

  initial begin
    @(negedge clk);
    run_topology(1'b0, 1'b0, 60);      // wide
    async_reset_probe();
    run_topology(1'b1, 1'b0, 60);      // paired, first mapping
    async_reset_probe();
    run_topology(1'b1, 1'b1, 60);      // paired, second mapping
    // Directed: long freeze with toggling inputs (R4 data hold, R3 control update)
    for (int c = 0; c < 8; c++) begin
      ball_in = (c % 2 == 0) ? '1 : '0;
      dcs_n = 1'b1; csr_n = 1'b1;
      tick();
    end
    async_reset_probe();
    run_topology(1'b0, 1'b1, 20);      // wide with selector strap high
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule